// File: doc/BRIEF.md
# Fly-by DMA Cycle Sequencer

This block runs one fly-by DMA transfer cycle at a time. Devices raise per-channel request lines. The sequencer picks one channel by fixed priority and asks the processor for the bus through a hold request. Once the hold acknowledge comes back, it presents the transfer address. The high address byte goes out on the shared data bus with a one-clock address strobe, so that an external latch can capture it. The low byte goes out on dedicated address pins.

It then acknowledges the chosen device and asserts a memory strobe together with the complementary I/O strobe. Data therefore moves directly between memory and the device without passing through the block. Channel 0 serves memory refresh and runs the shortest cycle. Every other channel adds two wait clocks, and each of these stretches for as long as the ready input stays low.

When the device drops its request, the hold request is released and the bus returns to the processor. Address counting and channel programming live elsewhere.

Top module: `dma_fb_seq`

## Requirements
- R1: During and right after synchronous reset, hold_req is 0, every ack_n bit is 1, all four command strobes are 1 (inactive), and adr_stb, dbus_oe and addr_oe are 0.
- R2: A request on any channel in the idle state raises hold_req on the next clock. No address strobe and no command strobe appears while hold_ack stays low.
- R3: When several channels request at once, the lowest-numbered channel is served.
- R4: The clock after hold_ack is sampled high is the address phase, which lasts exactly one clock. In it adr_stb is 1, dbus_oe is 1, dbus_out equals xfer_addr[15:8] and addr_lo equals xfer_addr[7:0], with addr_oe at 1.
- R5: During the strobe phase only bit i of ack_n is 0, where i is the granted channel. All other ack_n bits stay 1.
- R6: If the granted channel's dir bit is 1 (memory to I/O), mem_rd_n and io_wr_n go low together. If it is 0 (I/O to memory), io_rd_n and mem_wr_n go low together. dbus_oe is 0 throughout the strobe phase.
- R7: For channel 0, the strobes last exactly 2 clocks and rdy has no effect.
- R8: For channels 1 to 3, the strobes last 2 clocks plus 2 wait clocks. Each wait clock repeats for every clock edge at which rdy is sampled low. rdy is ignored during the first 2 clocks.
- R9: After the strobes end, hold_req stays at 1 while the granted channel still requests. It falls on the clock after that request drops, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NCH | Per-channel transfer request, active high |
| dir | input | NCH | Per-channel direction, 1 = memory to I/O |
| hold_ack | input | 1 | Bus grant from processor |
| rdy | input | 1 | Ready; low stretches wait clocks |
| xfer_addr | input | AW | Current transfer address |
| hold_req | output | 1 | Bus request to processor |
| ack_n | output | NCH | Per-channel acknowledge, active low |
| adr_stb | output | 1 | High-byte address latch strobe |
| dbus_oe | output | 1 | Data bus drive enable |
| dbus_out | output | 8 | High address byte on data bus |
| addr_oe | output | 1 | Low address drive enable |
| addr_lo | output | AW-8 | Low address bits |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |

## Verification
The bench builds the block with its defaults: four channels, a 16-bit address, 2 base clocks and 2 wait clocks. At this size every channel, both directions and every request mask can be swept. Each channel and direction is run with 0, 1 and 2 clocks of ready stall, and with varying hold-acknowledge delays. All 15 non-zero request masks are also run, to check the priority choice. Since rdy is held low from the start of each strobe phase, every run also shows that rdy has no effect during the base clocks and on the refresh channel.

// File: rtl/dma_fb_pkg.sv
package dma_fb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_ADDR,
        ST_XFER,
        ST_DONE
    } seq_state_e;

    // internal command set, active high
    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } cmd_t;

    localparam int DEF_BASE_CLKS = 2;
    localparam int DEF_WAIT_CLKS = 2;
    localparam int REFRESH_CH    = 0;

    function automatic cmd_t cmd_for(input logic mem_to_io, input logic active);
        cmd_t c;
        c.mem_rd = active &  mem_to_io;
        c.io_wr  = active &  mem_to_io;
        c.io_rd  = active & ~mem_to_io;
        c.mem_wr = active & ~mem_to_io;
        return c;
    endfunction

endpackage

// File: rtl/dma_fb_arb.sv
module dma_fb_arb #(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req,
    input  logic [NCH-1:0] dir,
    input  logic           load,
    output logic           any_req,
    output logic [CW-1:0]  grant_idx,
    output logic [NCH-1:0] grant_vec,
    output logic           grant_dir
);
    logic [CW-1:0]  pick_idx;
    logic [NCH-1:0] pick_vec;

    // lowest index wins
    always_comb begin
        pick_idx = '0;
        pick_vec = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick_idx = CW'(i);
                pick_vec = NCH'(1) << i;
            end
        end
    end

    assign any_req = |req;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_idx <= '0;
            grant_vec <= '0;
            grant_dir <= 1'b0;
        end else if (load) begin
            grant_idx <= pick_idx;
            grant_vec <= pick_vec;
            grant_dir <= dir[pick_idx];
        end
    end

endmodule

// File: rtl/dma_fb_timer.sv
module dma_fb_timer #(
    parameter int BASE_CLKS = 2,
    parameter int WAIT_CLKS = 2,
    localparam int CNTW = $clog2(BASE_CLKS + WAIT_CLKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic refresh,
    input  logic rdy,
    output logic last
);
    localparam logic [CNTW-1:0] SHORT_END = CNTW'(BASE_CLKS - 1);
    localparam logic [CNTW-1:0] LONG_END  = CNTW'(BASE_CLKS + WAIT_CLKS - 1);
    localparam logic [CNTW-1:0] WAIT_FROM = CNTW'(BASE_CLKS);

    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] end_cnt;
    logic            in_wait;
    logic            adv;

    assign end_cnt = refresh ? SHORT_END : LONG_END;
    assign in_wait = (cnt >= WAIT_FROM);
    assign adv     = ~in_wait | rdy;
    assign last    = run & adv & (cnt == end_cnt);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (adv && !last) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dma_fb_outdec.sv
module dma_fb_outdec
    import dma_fb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16
) (
    input  seq_state_e     state,
    input  logic [NCH-1:0] grant_vec,
    input  logic           grant_dir,
    input  logic [AW-1:0]  xfer_addr,
    output logic           hold_req,
    output logic [NCH-1:0] ack_n,
    output logic           adr_stb,
    output logic           dbus_oe,
    output logic [7:0]     dbus_out,
    output logic           addr_oe,
    output logic [AW-9:0]  addr_lo,
    output logic           mem_rd_n,
    output logic           mem_wr_n,
    output logic           io_rd_n,
    output logic           io_wr_n
);
    logic in_addr;
    logic in_xfer;
    cmd_t cmd;

    assign in_addr  = (state == ST_ADDR);
    assign in_xfer  = (state == ST_XFER);
    assign hold_req = (state != ST_IDLE);

    assign adr_stb  = in_addr;
    assign dbus_oe  = in_addr;
    assign dbus_out = in_addr ? xfer_addr[AW-1:AW-8] : 8'h00;
    assign addr_oe  = in_addr | in_xfer;
    assign addr_lo  = (in_addr | in_xfer) ? xfer_addr[AW-9:0] : '0;

    assign ack_n    = in_xfer ? ~grant_vec : '1;

    assign cmd      = cmd_for(grant_dir, in_xfer);
    assign mem_rd_n = ~cmd.mem_rd;
    assign mem_wr_n = ~cmd.mem_wr;
    assign io_rd_n  = ~cmd.io_rd;
    assign io_wr_n  = ~cmd.io_wr;

endmodule

// File: rtl/dma_fb_seq.sv
module dma_fb_seq
    import dma_fb_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int AW        = 16,
    parameter int BASE_CLKS = DEF_BASE_CLKS,
    parameter int WAIT_CLKS = DEF_WAIT_CLKS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req,
    input  logic [NCH-1:0] dir,
    input  logic           hold_ack,
    input  logic           rdy,
    input  logic [AW-1:0]  xfer_addr,
    output logic           hold_req,
    output logic [NCH-1:0] ack_n,
    output logic           adr_stb,
    output logic           dbus_oe,
    output logic [7:0]     dbus_out,
    output logic           addr_oe,
    output logic [AW-9:0]  addr_lo,
    output logic           mem_rd_n,
    output logic           mem_wr_n,
    output logic           io_rd_n,
    output logic           io_wr_n
);
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

    seq_state_e     state, state_nx;
    logic           any_req;
    logic           load;
    logic [CW-1:0]  grant_idx;
    logic [NCH-1:0] grant_vec;
    logic           grant_dir;
    logic           refresh;
    logic           last;

    assign load    = (state == ST_IDLE) & any_req;
    assign refresh = (grant_idx == CW'(REFRESH_CH));

    dma_fb_arb #(.NCH(NCH)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .dir       (dir),
        .load      (load),
        .any_req   (any_req),
        .grant_idx (grant_idx),
        .grant_vec (grant_vec),
        .grant_dir (grant_dir)
    );

    dma_fb_timer #(.BASE_CLKS(BASE_CLKS), .WAIT_CLKS(WAIT_CLKS)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_XFER),
        .refresh (refresh),
        .rdy     (rdy),
        .last    (last)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (any_req)         state_nx = ST_HOLD;
            ST_HOLD: if (hold_ack)        state_nx = ST_ADDR;
            ST_ADDR:                      state_nx = ST_XFER;
            ST_XFER: if (last)            state_nx = ST_DONE;
            ST_DONE: if (!req[grant_idx]) state_nx = ST_IDLE;
            default:                      state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    dma_fb_outdec #(.NCH(NCH), .AW(AW)) u_dec (
        .state     (state),
        .grant_vec (grant_vec),
        .grant_dir (grant_dir),
        .xfer_addr (xfer_addr),
        .hold_req  (hold_req),
        .ack_n     (ack_n),
        .adr_stb   (adr_stb),
        .dbus_oe   (dbus_oe),
        .dbus_out  (dbus_out),
        .addr_oe   (addr_oe),
        .addr_lo   (addr_lo),
        .mem_rd_n  (mem_rd_n),
        .mem_wr_n  (mem_wr_n),
        .io_rd_n   (io_rd_n),
        .io_wr_n   (io_wr_n)
    );

endmodule

// File: rtl/dma_fb_chk.sv
module dma_fb_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           hold_ack,
    input logic           hold_req,
    input logic [NCH-1:0] ack_n,
    input logic           adr_stb,
    input logic           dbus_oe,
    input logic           mem_rd_n,
    input logic           mem_wr_n,
    input logic           io_rd_n,
    input logic           io_wr_n
);
    logic cmd_on;
    assign cmd_on = ~mem_rd_n | ~mem_wr_n;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!hold_req && (&ack_n) && !adr_stb && mem_rd_n && mem_wr_n));

    p_stb_after_grant_r2: assert property (@(posedge clk) disable iff (rst)
        adr_stb |-> (hold_req && $past(hold_ack)));

    p_stb_one_clk_r4: assert property (@(posedge clk) disable iff (rst)
        adr_stb |=> !adr_stb);

    p_single_ack_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(~ack_n) <= 1);

    p_ack_with_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_on |-> ($countones(~ack_n) == 1));

    p_rd_pair_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_n |-> (!io_wr_n && mem_wr_n && io_rd_n));

    p_wr_pair_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |-> (!io_rd_n && mem_rd_n && io_wr_n));

    p_bus_free_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_on |-> !dbus_oe);

    p_cmd_min_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_on) |=> cmd_on);

    p_hold_covers_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_on |-> hold_req);

endmodule

bind dma_fb_seq dma_fb_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hold_ack (hold_ack),
    .hold_req (hold_req),
    .ack_n    (ack_n),
    .adr_stb  (adr_stb),
    .dbus_oe  (dbus_oe),
    .mem_rd_n (mem_rd_n),
    .mem_wr_n (mem_wr_n),
    .io_rd_n  (io_rd_n),
    .io_wr_n  (io_wr_n)
);

// File: tb/sim_dma_fb_seq.sv
`timescale 1ns/1ps
module sim_dma_fb_seq;
    localparam int NCH = 4;
    localparam int AW  = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] req = '0;
    logic [NCH-1:0] dir = '0;
    logic           hold_ack = 1'b0;
    logic           rdy = 1'b0;
    logic [AW-1:0]  xfer_addr = '0;
    logic           hold_req;
    logic [NCH-1:0] ack_n;
    logic           adr_stb, dbus_oe, addr_oe;
    logic [7:0]     dbus_out;
    logic [AW-9:0]  addr_lo;
    logic           mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    dma_fb_seq #(.NCH(NCH), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .req(req), .dir(dir), .hold_ack(hold_ack),
        .rdy(rdy), .xfer_addr(xfer_addr), .hold_req(hold_req), .ack_n(ack_n),
        .adr_stb(adr_stb), .dbus_oe(dbus_oe), .dbus_out(dbus_out),
        .addr_oe(addr_oe), .addr_lo(addr_lo), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
    endfunction

    task automatic do_xfer(input logic [NCH-1:0] mask, input logic [NCH-1:0] dirs,
                           input int stall, input int hd, input logic [AW-1:0] a);
        int ch = 0;
        int n = 0;
        int exp_len;
        logic [3:0] exp_stb;
        for (int i = NCH - 1; i >= 0; i--) if (mask[i]) ch = i;
        exp_len = (ch == 0) ? 2 : 4 + stall;
        // order mem_rd_n, mem_wr_n, io_rd_n, io_wr_n
        exp_stb = dirs[ch] ? 4'b0110 : 4'b1001;

        @(negedge clk);
        req = mask; dir = dirs; xfer_addr = a; hold_ack = 1'b0; rdy = 1'b0;
        @(negedge clk);
        chk(hold_req === 1'b1, "R2 hold_req", {31'd0, hold_req}, 1);
        for (int k = 0; k < hd; k++) begin
            chk(!adr_stb && strobes() == 4'hF, "R2 no cycle before grant",
                {27'd0, adr_stb, strobes()}, 32'hF);
            @(negedge clk);
        end
        chk(!adr_stb && strobes() == 4'hF, "R2 no cycle before grant",
            {27'd0, adr_stb, strobes()}, 32'hF);
        hold_ack = 1'b1;
        @(negedge clk);
        chk(adr_stb && dbus_oe && addr_oe, "R4 address phase enables",
            {29'd0, adr_stb, dbus_oe, addr_oe}, 7);
        chk(dbus_out == a[15:8], "R4 high byte", {24'd0, dbus_out}, {24'd0, a[15:8]});
        chk(addr_lo == a[7:0], "R4 low byte", {24'd0, addr_lo}, {24'd0, a[7:0]});
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (strobes() == 4'hF) break;
            n++;
            chk(ack_n == ~(NCH'(1) << ch), "R3 R5 ack select", {28'd0, ack_n},
                {28'd0, ~(NCH'(1) << ch)});
            chk(strobes() == exp_stb, "R6 strobe pair", {28'd0, strobes()}, {28'd0, exp_stb});
            chk(!dbus_oe && !adr_stb, "R6 R4 data bus released",
                {30'd0, dbus_oe, adr_stb}, 0);
            rdy = (n > 2 + stall);
        end
        chk(n == exp_len, (ch == 0) ? "R7 refresh length" : "R8 wait length",
            n, exp_len);
        chk(hold_req && (&ack_n), "R9 hold kept until request drops",
            {27'd0, hold_req, ack_n}, {27'd0, 1'b1, 4'hF});
        req = '0;
        @(negedge clk);
        chk(!hold_req, "R9 hold released", {31'd0, hold_req}, 0);
        hold_ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!hold_req && (&ack_n) && strobes() == 4'hF && !adr_stb && !dbus_oe && !addr_oe,
            "R1 reset state", {24'd0, hold_req, ack_n, strobes()}, {24'd0, 1'b0, 4'hF, 4'hF});
        rst = 1'b0;
        @(negedge clk);
        chk(!hold_req && strobes() == 4'hF, "R1 idle after reset",
            {27'd0, hold_req, strobes()}, 32'hF);
        // every channel, both directions, stall 0..2
        for (int ch = 0; ch < NCH; ch++)
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < 3; s++)
                    do_xfer(NCH'(1) << ch, d ? '1 : '0, s, (ch + s) % 3,
                            AW'(16'h1234 + (ch * 6 + d * 3 + s) * 16'h0F1D));
        // every request mask for priority
        for (int m = 1; m < (1 << NCH); m++)
            do_xfer(NCH'(m), NCH'(m * 5), m % 2, m % 3, AW'(16'hA5C3 ^ (m * 16'h1111)));
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule